// File: doc/BRIEF.md
# Printer Port Register Block

This block is the byte-wide register face of a legacy printer port. It sits on a simple strobed register bus and holds three registers: a data register, a status register and a control register. A three-bit offset taken from the bottom of the bus address picks the register. There is no real printer behind the block. The strobe/busy/acknowledge handshake that software expects is emulated internally.

A control write that raises the strobe with the port selected and out of initialization hands the latched data byte to an output byte stream. This appears as a one-cycle valid pulse. Software can then poll the status register. Each such read walks the emulated acknowledge/busy sequence one step and drops any pending interrupt. The interrupt output is a single level that stays high while an interrupt is pending.

Input bytes from an external source are captured into a separate input latch by a load strobe. They are returned on data reads when the control direction bit selects input.

Top module: `lpt_regblock`

## Requirements
- R1: After reset a data read returns 0xFF, a status read returns 0xD9, a control read returns 0xCC, `irq` is low and `out_valid` is low.
- R2: Only address bits 2:0 are decoded: offset 0 is data, 1 is status and 2 is control. Reads at offsets 3 to 7 return 0xFF, and writes there change no register.
- R3: A control write stores the written value with bits 7:6 forced to 1. A control read returns that stored value.
- R4: A control write with bit 2 (INIT) equal to 0 sets status to 0xD8. In that value BUSY (bit 7), ACK (bit 6), ONLINE (bit 4) and ERROR (bit 3) are set, and timeout (bit 0) is clear.
- R5: A control write with INIT (bit 2), SELECT (bit 3) and STROBE (bit 0) all at 1 clears status bit 7 (BUSY).
- R6: If such a write finds STROBE at 0 in the previously stored control value, `out_byte` carries the data-register byte and `out_valid` is high for exactly the cycle after the write edge.
- R7: A control write with INIT=1, SELECT=1 and STROBE=0, made while the stored control has bit 4 (interrupt enable) at 1, makes `irq` high from the cycle after the write.
- R8: A status read clears the pending interrupt, so `irq` is low from the cycle after the read. A data read leaves it alone.
- R9: A status read returns the status before any change. If status bit 7 is 0 and control bit 0 is 0, the read then clears bit 6 when it is set, and otherwise sets bits 7 and 6.
- R10: A data read returns the input latch (last `in_byte` loaded by `in_load`) when control bit 5 is 1, and the last written data byte when it is 0.
- R11: A control write with STROBE=1 when the stored control already has STROBE=1 emits no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address; bits 2:0 decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read side effects occur on its clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| in_byte | input | 8 | Byte from the external input source |
| in_load | input | 1 | Captures `in_byte` into the input latch |
| out_byte | output | 8 | Emitted byte |
| out_valid | output | 1 | One-cycle pulse marking `out_byte` valid |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The hardest state to reach is the acknowledge toggle in the status sequence. It needs BUSY already cleared by a strobe-high write, followed by a strobe-low write that keeps INIT and SELECT set, so that status reads step rather than hold. The bench gets there by emitting a byte first, then dropping the strobe, and then reading status three times so that both branches of the step and the final hold are each seen. The interrupt path is similar. It needs interrupt enable already stored before a strobe-low write, so the bench writes the same enabling control value twice and checks that the first write raises nothing.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

  // status bit positions
  localparam int ST_BUSY_N = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_ERR_N  = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR   = 5;
  localparam int CT_IRQEN = 4;
  localparam int CT_SEL   = 3;
  localparam int CT_INIT  = 2;
  localparam int CT_AFD   = 1;
  localparam int CT_STB   = 0;

  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_RESET = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] DATA_RESET = 8'hFF;
  localparam logic [BYTE_W-1:0] RD_FILL    = 8'hFF;

  // value actually stored for a control write
  function automatic logic [BYTE_W-1:0] ctrl_image(input logic [BYTE_W-1:0] w);
    return w | CTRL_FORCE;
  endfunction

  // port selected and out of initialization
  function automatic logic handshake_armed(input logic [BYTE_W-1:0] c);
    return c[CT_INIT] & c[CT_SEL];
  endfunction

  // one step of the emulated acknowledge/busy sequence on a status poll
  function automatic logic [BYTE_W-1:0] poll_step(input logic [BYTE_W-1:0] st,
                                                  input logic              stb);
    logic [BYTE_W-1:0] n;
    n = st;
    if (!st[ST_BUSY_N] && !stb) begin
      if (st[ST_ACK]) begin
        n[ST_ACK] = 1'b0;
      end else begin
        n[ST_ACK]    = 1'b1;
        n[ST_BUSY_N] = 1'b1;
      end
    end
    return n;
  endfunction

  // register read selection
  function automatic logic [BYTE_W-1:0] read_select(input logic [OFF_W-1:0]  off,
                                                    input logic [BYTE_W-1:0] ctrl,
                                                    input logic [BYTE_W-1:0] stat,
                                                    input logic [BYTE_W-1:0] outl,
                                                    input logic [BYTE_W-1:0] inl);
    logic [BYTE_W-1:0] r;
    case (off)
      OFF_DATA: r = ctrl[CT_DIR] ? inl : outl;
      OFF_STAT: r = stat;
      OFF_CTRL: r = ctrl;
      default:  r = RD_FILL;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lpt_ctrl_unit.sv
module lpt_ctrl_unit
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic              init_evt,
  output logic              busy_clr_evt,
  output logic              emit_evt,
  output logic              irq_set_evt
);

  logic [BYTE_W-1:0] next_img;
  logic              armed_wr;

  always_comb begin
    next_img     = ctrl_image(wdata);
    armed_wr     = wr_en & handshake_armed(next_img);
    init_evt     = wr_en & ~next_img[CT_INIT];
    busy_clr_evt = armed_wr & next_img[CT_STB];
    emit_evt     = busy_clr_evt & ~ctrl_q[CT_STB];
    irq_set_evt  = armed_wr & ~next_img[CT_STB] & ctrl_q[CT_IRQEN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en) begin
      ctrl_q <= next_img;
    end
  end

endmodule

// File: rtl/lpt_status_unit.sv
module lpt_status_unit
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_evt,
  input  logic              busy_clr_evt,
  input  logic              irq_set_evt,
  input  logic              poll_evt,
  input  logic              ctrl_stb,
  output logic [BYTE_W-1:0] status_q,
  output logic              irq_pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STAT_RESET;
    end else if (init_evt) begin
      status_q <= STAT_INIT;
    end else if (busy_clr_evt) begin
      status_q[ST_BUSY_N] <= 1'b0;
    end else if (poll_evt) begin
      status_q <= poll_step(status_q, ctrl_stb);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pend <= 1'b0;
    end else if (irq_set_evt) begin
      irq_pend <= 1'b1;
    end else if (poll_evt) begin
      irq_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/lpt_data_unit.sv
module lpt_data_unit
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              in_load,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              emit_evt,
  output logic [BYTE_W-1:0] out_latch,
  output logic [BYTE_W-1:0] in_latch,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_latch <= DATA_RESET;
    end else if (wr_en) begin
      out_latch <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_latch <= DATA_RESET;
    end else if (in_load) begin
      in_latch <= in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit_evt;
      if (emit_evt) begin
        out_byte <= out_latch;
      end
    end
  end

endmodule

// File: rtl/lpt_regblock.sv
module lpt_regblock
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        in_byte,
  input  logic              in_load,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              irq
);

  logic [OFF_W-1:0]  off;
  logic              wr_data;
  logic              wr_ctrl;
  logic              poll_evt;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] status_q;
  logic [BYTE_W-1:0] out_latch;
  logic [BYTE_W-1:0] in_latch;
  logic              init_evt;
  logic              busy_clr_evt;
  logic              emit_evt;
  logic              irq_set_evt;
  logic              irq_pend;

  assign off      = bus_addr[OFF_W-1:0];
  assign wr_data  = bus_wr & (off == OFF_DATA);
  assign wr_ctrl  = bus_wr & (off == OFF_CTRL);
  assign poll_evt = bus_rd & ~bus_wr & (off == OFF_STAT);

  lpt_ctrl_unit u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_ctrl),
    .wdata        (bus_wdata),
    .ctrl_q       (ctrl_q),
    .init_evt     (init_evt),
    .busy_clr_evt (busy_clr_evt),
    .emit_evt     (emit_evt),
    .irq_set_evt  (irq_set_evt)
  );

  lpt_status_unit u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_evt     (init_evt),
    .busy_clr_evt (busy_clr_evt),
    .irq_set_evt  (irq_set_evt),
    .poll_evt     (poll_evt),
    .ctrl_stb     (ctrl_q[CT_STB]),
    .status_q     (status_q),
    .irq_pend     (irq_pend)
  );

  lpt_data_unit u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_data),
    .wdata     (bus_wdata),
    .in_load   (in_load),
    .in_byte   (in_byte),
    .emit_evt  (emit_evt),
    .out_latch (out_latch),
    .in_latch  (in_latch),
    .out_byte  (out_byte),
    .out_valid (out_valid)
  );

  assign bus_rdata = read_select(off, ctrl_q, status_q, out_latch, in_latch);
  assign irq       = irq_pend;

endmodule

// File: rtl/lpt_regblock_chk.sv
module lpt_regblock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] off,
  input logic       wr_ctrl,
  input logic       poll_evt,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] ctrl_q,
  input logic [7:0] status_q,
  input logic       emit_evt,
  input logic       irq_set_evt,
  input logic       out_valid,
  input logic       irq
);

  assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_q == ({2'b11, $past(bus_wdata[5:0])})));

  assert_init_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[2]) |=> (status_q == 8'hD8));

  assert_busy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[2] && bus_wdata[3] && bus_wdata[0]) |=> !status_q[7]);

  assert_emit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    emit_evt |=> out_valid);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_evt |=> irq);

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_evt && !wr_ctrl) |=> !irq);

  assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (off > 3'd2) |-> (bus_rdata == 8'hFF));

  assert_no_reemit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl_q[0]) |=> !out_valid);

endmodule

bind lpt_regblock lpt_regblock_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .off         (off),
  .wr_ctrl     (wr_ctrl),
  .poll_evt    (poll_evt),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .ctrl_q      (ctrl_q),
  .status_q    (status_q),
  .emit_evt    (emit_evt),
  .irq_set_evt (irq_set_evt),
  .out_valid   (out_valid),
  .irq         (irq)
);

// File: tb/sim_lpt_regblock.sv
`timescale 1ns/1ps
module sim_lpt_regblock;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [7:0]    in_byte = '0;
  logic          in_load = 1'b0;
  logic [7:0]    out_byte;
  logic          out_valid;
  logic          irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpt_regblock #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_byte(in_byte), .in_load(in_load), .out_byte(out_byte),
    .out_valid(out_valid), .irq(irq)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // write completes at the edge; returns at the following negedge
  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // samples combinational data before the edge that applies side effects
  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check1("R1 irq after reset", irq, 1'b0);
    check1("R1 out_valid after reset", out_valid, 1'b0);
    bus_read(8'd0, v); check8("R1 data reset", v, 8'hFF);
    bus_read(8'd1, v); check8("R1 status reset", v, 8'hD9);
    bus_read(8'd2, v); check8("R1 control reset", v, 8'hCC);
  endtask

  task automatic t_ctrl_force();
    logic [7:0] v;
    bus_write(8'd2, 8'h0C); bus_read(8'd2, v); check8("R3 force 7:6", v, 8'hCC);
    bus_write(8'd2, 8'h2C); bus_read(8'd2, v); check8("R3 force with dir", v, 8'hEC);
    bus_write(8'd2, 8'h0C); bus_read(8'd2, v); check8("R3 restore", v, 8'hCC);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    bus_write(8'h08, 8'h5A);
    bus_read(8'd0, v); check8("R2 aliased data write", v, 8'h5A);
    for (int k = 3; k < 8; k++) begin
      bus_read(AW'(k), v); check8("R2 unmapped read", v, 8'hFF);
    end
    for (int k = 3; k < 8; k++) bus_write(AW'(k), 8'h00);
    bus_read(8'd0, v);  check8("R2 data after unmapped writes", v, 8'h5A);
    bus_read(8'h0A, v); check8("R2 control after unmapped writes", v, 8'hCC);
    bus_read(8'd1, v);  check8("R2 status after unmapped writes", v, 8'hD9);
  endtask

  task automatic t_emit();
    logic [7:0] v;
    bus_write(8'd2, 8'h0D);
    check1("R6 out_valid after strobe rise", out_valid, 1'b1);
    check8("R6 out_byte", out_byte, 8'h5A);
    @(negedge clk);
    check1("R6 pulse one cycle", out_valid, 1'b0);
    bus_read(8'd1, v); check8("R5 busy cleared", v, 8'h59);
    bus_read(8'd1, v); check8("R9 no step while strobe high", v, 8'h59);
  endtask

  task automatic t_no_reemit();
    bus_write(8'd2, 8'h0D);
    check1("R11 no emit on repeated strobe", out_valid, 1'b0);
    @(negedge clk);
    check1("R11 still no emit", out_valid, 1'b0);
  endtask

  task automatic t_poll_step();
    logic [7:0] v;
    bus_write(8'd2, 8'h0C);
    check1("R7 no irq without enable", irq, 1'b0);
    bus_read(8'd1, v); check8("R9 first poll", v, 8'h59);
    bus_read(8'd1, v); check8("R9 ack cleared", v, 8'h19);
    bus_read(8'd1, v); check8("R9 ack and busy set", v, 8'hD9);
    bus_read(8'd1, v); check8("R9 hold when busy set", v, 8'hD9);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bus_write(8'd2, 8'h1C);
    check1("R7 enable not yet stored", irq, 1'b0);
    bus_write(8'd2, 8'h1C);
    check1("R7 irq raised", irq, 1'b1);
    bus_read(8'd0, v);
    check1("R8 data read keeps irq", irq, 1'b1);
    bus_read(8'd1, v);
    check1("R8 status read clears irq", irq, 1'b0);
  endtask

  task automatic t_init();
    logic [7:0] v;
    bus_write(8'd2, 8'h0D);
    check1("R6 emit after enable phase", out_valid, 1'b1);
    bus_read(8'd1, v); check8("R5 busy cleared again", v, 8'h59);
    bus_write(8'd2, 8'h08);
    bus_read(8'd1, v); check8("R4 init sets status", v, 8'hD8);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    @(negedge clk); in_byte = 8'hA5; in_load = 1'b1;
    @(negedge clk); in_load = 1'b0;
    bus_read(8'd0, v); check8("R10 output latch while dir=0", v, 8'h5A);
    bus_write(8'd2, 8'h2C);
    bus_read(8'd0, v); check8("R10 input latch while dir=1", v, 8'hA5);
    bus_write(8'd2, 8'h0C);
    bus_read(8'd0, v); check8("R10 back to output latch", v, 8'h5A);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl_force();
    t_decode();
    t_emit();
    t_no_reemit();
    t_poll_step();
    t_irq();
    t_init();
    t_dir();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule